// File: doc/BRIEF.md
# Memory Pattern Test Engine

This block is a self-running hardware tester for a single-port synchronous RAM. It replaces a manual debugger session of pattern fills and read-backs. A single start pulse launches a fixed sequence. First comes a data-line pass, which fills the whole memory with a solid pattern and reads it back. Then comes an address-line pass, which looks for aliasing between low and high locations.

The address pass first clears the memory to zero. It then marks a block at the bottom of memory with all ones and reads every word above the block. Any all-ones word found above the block shows that an address line is shorted or open. The marked block starts at 16 words and doubles after each clean scan, until it would cover the whole memory.

The engine stops at the first bad read. It reports the address, the expected word, the observed word and a phase code. A mode input picks the data-line patterns: solid zeros and ones, or two alternating-bit words.

Top module: `memtest_engine`

## Requirements
- R1: A synchronous active-high reset, or a reset in mid-run, leaves busy, done, pass, fail and both memory strobes low.
- R2: With mode low, the data pass writes then reads every address three times, with the patterns 0x0000, 0xFFFF and 0x0000 in that order. A clean run issues 4·D + 48 writes and 3·D + 80 reads for D = 64 words.
- R3: With mode high, the data pass writes then reads every address with 0xAAAA and then 0x5555. A clean run issues 3·D + 48 writes and 2·D + 80 reads.
- R4: The address pass writes 0x0000 to every word. For each block size B = 16, 32, … below D, it writes 0xFFFF to addresses 0..B−1 and then reads addresses B..D−1.
- R5: In the address pass, a read that returns 0xFFFF is a failure. It is reported with phase code 3, expected 0x0000, observed 0xFFFF and the address that was read.
- R6: In the data pass, a read that differs from the written pattern in any bit is a failure. It is reported with its address, the expected and observed words, and phase code 1 for mode low or 2 for mode high. Pass and fail are never high together.
- R7: At the first failure the engine stops early, raises done and keeps the first error's details, with fail held high.
- R8: Done is a one-cycle pulse. In a clean run, pass is high with it and stays high until the next start. Done comes (AW+3)·D+3 clock edges after the start edge in mode low, and (AW+1)·D+3 edges in mode high.
- R9: A start pulse while busy is ignored: the run keeps its mode and its length.
- R10: Read data is taken one cycle after the read strobe, and write and read strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, taken only when idle |
| mode | input | 1 | Data patterns: 0 solid zeros/ones, 1 alternating bits |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | DW | Memory read data, valid one cycle after mem_re |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Last run completed without error |
| fail | output | 1 | A mismatch was found |
| err_addr | output | AW | Address of the first mismatch |
| err_exp | output | DW | Expected word at the first mismatch |
| err_obs | output | DW | Observed word at the first mismatch |
| err_phase | output | 2 | 1 solid data, 2 alternating data, 3 aliasing |

## Verification
The memory strobes are registered, so each read's data arrives two cycles after the sequencer issues it. A mismatch is latched one cycle after that, and done with pass follows one cycle after the sequencer reaches its end state. This gives the exact run lengths of 579 and 451 edges for 64 words. The bench counts posedges from the start edge and samples 1 ns after each edge, so a clean run's done must appear on exactly that count. Failure runs are checked only after done, and all their error fields are compared at that point, so the depth of the internal pipeline does not affect them.

// File: rtl/memtest_pkg.sv
package memtest_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DWR, ST_DRD, ST_ACLR, ST_AMARK, ST_ASCAN,
    ST_DRN1, ST_DRN2, ST_DONE
  } st_e;

  localparam logic [1:0] PH_NONE  = 2'd0;
  localparam logic [1:0] PH_SOLID = 2'd1;
  localparam logic [1:0] PH_CHECK = 2'd2;
  localparam logic [1:0] PH_ALIAS = 2'd3;

endpackage

// File: rtl/memtest_seq.sv
module memtest_seq
  import memtest_pkg::*;
#(
  parameter int AW   = 6,
  parameter int DW   = 16,
  parameter int BLK0 = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          mode,
  input  logic          err_seen,
  output st_e           st,
  output logic          req_we,
  output logic          req_re,
  output logic          req_alias,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  output logic [DW-1:0] req_exp,
  output logic [1:0]    req_phase
);

  localparam logic [AW-1:0] TOP_A    = '1;
  localparam logic [AW-1:0] BLK_INIT = AW'(BLK0);
  localparam logic [AW-1:0] BLK_LAST = AW'(1 << (AW - 1));
  localparam logic [DW-1:0] ONES     = '1;
  localparam logic [DW-1:0] ZERO     = '0;
  localparam logic [DW-1:0] CHK_HI   = {(DW/2){2'b10}};
  localparam logic [DW-1:0] CHK_LO   = ~CHK_HI;

  logic [AW-1:0] addr;
  logic [AW-1:0] blk;
  logic [1:0]    stage;
  logic          mode_q;
  logic [DW-1:0] pat;
  logic          last_stage;
  logic          at_top;

  always_comb begin
    if (mode_q) pat = (stage == 2'd0) ? CHK_HI : CHK_LO;
    else        pat = (stage == 2'd1) ? ONES : ZERO;
    last_stage = mode_q ? (stage == 2'd1) : (stage == 2'd2);
    at_top     = (addr == TOP_A);
  end

  always_comb begin
    req_we    = 1'b0;
    req_re    = 1'b0;
    req_alias = 1'b0;
    req_addr  = addr;
    req_wdata = ZERO;
    req_exp   = ZERO;
    req_phase = PH_NONE;
    case (st)
      ST_DWR:   begin req_we = 1'b1; req_wdata = pat; end
      ST_DRD:   begin
        req_re    = 1'b1;
        req_exp   = pat;
        req_phase = mode_q ? PH_CHECK : PH_SOLID;
      end
      ST_ACLR:  req_we = 1'b1;
      ST_AMARK: begin req_we = 1'b1; req_wdata = ONES; end
      ST_ASCAN: begin
        req_re    = 1'b1;
        req_alias = 1'b1;
        req_phase = PH_ALIAS;
      end
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      addr   <= '0;
      blk    <= BLK_INIT;
      stage  <= 2'd0;
      mode_q <= 1'b0;
    end else if (st == ST_IDLE) begin
      if (start) begin
        st     <= ST_DWR;
        addr   <= '0;
        stage  <= 2'd0;
        mode_q <= mode;
      end
    end else if (err_seen && st != ST_DONE) begin
      st <= ST_DONE;
    end else begin
      case (st)
        ST_DWR: begin
          addr <= addr + 1'b1;
          if (at_top) st <= ST_DRD;
        end
        ST_DRD: begin
          addr <= addr + 1'b1;
          if (at_top) begin
            if (last_stage) st <= ST_ACLR;
            else begin
              stage <= stage + 2'd1;
              st    <= ST_DWR;
            end
          end
        end
        ST_ACLR: begin
          addr <= addr + 1'b1;
          if (at_top) begin
            st  <= ST_AMARK;
            blk <= BLK_INIT;
          end
        end
        ST_AMARK: begin
          if (addr == blk - 1'b1) begin
            addr <= blk;
            st   <= ST_ASCAN;
          end else addr <= addr + 1'b1;
        end
        ST_ASCAN: begin
          addr <= addr + 1'b1;
          if (at_top) begin
            if (blk == BLK_LAST) st <= ST_DRN1;
            else begin
              blk <= blk << 1;
              st  <= ST_AMARK;
            end
          end
        end
        ST_DRN1: st <= ST_DRN2;
        ST_DRN2: st <= ST_DONE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R4: marking stays inside the block, scanning stays above it
  p_mark_below_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_AMARK) |-> (addr < blk));
  p_scan_above_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ASCAN) |-> (addr >= blk));

endmodule

// File: rtl/memtest_cmp.sv
module memtest_cmp #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          pend_re,
  input  logic          pend_alias,
  input  logic [AW-1:0] pend_addr,
  input  logic [DW-1:0] pend_exp,
  input  logic [1:0]    pend_phase,
  input  logic [DW-1:0] rdata,
  output logic          fail,
  output logic [AW-1:0] err_addr,
  output logic [DW-1:0] err_exp,
  output logic [DW-1:0] err_obs,
  output logic [1:0]    err_phase
);

  localparam logic [DW-1:0] ONES = '1;

  logic          v_q;
  logic          al_q;
  logic [AW-1:0] a_q;
  logic [DW-1:0] e_q;
  logic [1:0]    p_q;
  logic          mism;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q  <= 1'b0;
      al_q <= 1'b0;
      a_q  <= '0;
      e_q  <= '0;
      p_q  <= '0;
    end else begin
      v_q  <= pend_re;
      al_q <= pend_alias;
      a_q  <= pend_addr;
      e_q  <= pend_exp;
      p_q  <= pend_phase;
    end
  end

  assign mism = v_q && (al_q ? (rdata == ONES) : (rdata != e_q));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      fail      <= 1'b0;
      err_addr  <= '0;
      err_exp   <= '0;
      err_obs   <= '0;
      err_phase <= '0;
    end else if (mism && !fail) begin
      fail      <= 1'b1;
      err_addr  <= a_q;
      err_exp   <= e_q;
      err_obs   <= rdata;
      err_phase <= p_q;
    end
  end

  // R7: the first error's details are kept until the next start
  p_fail_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (fail && !clr) |=> (fail && $stable(err_addr) && $stable(err_obs)));

endmodule

// File: rtl/memtest_engine.sv
module memtest_engine
  import memtest_pkg::*;
#(
  parameter int AW   = 6,
  parameter int DW   = 16,
  parameter int BLK0 = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          mode,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic [AW-1:0] err_addr,
  output logic [DW-1:0] err_exp,
  output logic [DW-1:0] err_obs,
  output logic [1:0]    err_phase
);

  st_e           st;
  logic          req_we, req_re, req_alias;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata, req_exp;
  logic [1:0]    req_phase;
  logic          pend_alias;
  logic [DW-1:0] pend_exp;
  logic [1:0]    pend_phase;
  logic          launch;

  assign launch = (st == ST_IDLE) && start;
  assign busy   = (st != ST_IDLE);

  memtest_seq #(.AW(AW), .DW(DW), .BLK0(BLK0)) u_seq (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .err_seen(fail),
    .st(st), .req_we(req_we), .req_re(req_re), .req_alias(req_alias),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_exp(req_exp),
    .req_phase(req_phase)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we     <= 1'b0;
      mem_re     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      pend_alias <= 1'b0;
      pend_exp   <= '0;
      pend_phase <= '0;
      done       <= 1'b0;
      pass       <= 1'b0;
    end else begin
      mem_we     <= req_we;
      mem_re     <= req_re;
      mem_addr   <= req_addr;
      mem_wdata  <= req_wdata;
      pend_alias <= req_alias;
      pend_exp   <= req_exp;
      pend_phase <= req_phase;
      done       <= (st == ST_DONE);
      if (launch)                        pass <= 1'b0;
      else if (st == ST_DONE && !fail)   pass <= 1'b1;
    end
  end

  memtest_cmp #(.AW(AW), .DW(DW)) u_cmp (
    .clk(clk), .rst(rst), .clr(launch),
    .pend_re(mem_re), .pend_alias(pend_alias), .pend_addr(mem_addr),
    .pend_exp(pend_exp), .pend_phase(pend_phase), .rdata(mem_rdata),
    .fail(fail), .err_addr(err_addr), .err_exp(err_exp),
    .err_obs(err_obs), .err_phase(err_phase)
  );

  // R8: done lasts one cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R6: pass and fail exclusive
  p_pass_fail_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(pass && fail));
  // R9: a run only leaves busy through done
  p_busy_until_done_r9: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done));
  // R10: one strobe at a time
  p_port_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

endmodule

// File: tb/tb_memtest_engine.sv
`timescale 1ns/1ps
module tb_memtest_engine;

  localparam int AW = 6;
  localparam int DW = 16;
  localparam int D  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          mode = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we, mem_re;
  logic [DW-1:0] mem_rdata = '0;
  logic          busy, done, pass, fail;
  logic [AW-1:0] err_addr;
  logic [DW-1:0] err_exp, err_obs;
  logic [1:0]    err_phase;

  int checks = 0;
  int failures = 0;

  // memory model and fault controls
  logic [DW-1:0] mem [0:D-1];
  logic [DW-1:0] stuck_or = '0;
  logic [DW-1:0] stuck_and = '1;
  logic [AW-1:0] alias_mask = '0;
  int            bad_addr = -1;
  logic [DW-1:0] bad_xor = '0;
  logic          cnt_clr = 1'b0;
  int            n_wr = 0, n_rd = 0, n_ovl = 0;

  always #4 clk = ~clk;

  memtest_engine #(.AW(AW), .DW(DW), .BLK0(16)) dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_re(mem_re), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .pass(pass), .fail(fail), .err_addr(err_addr), .err_exp(err_exp),
    .err_obs(err_obs), .err_phase(err_phase)
  );

  always @(posedge clk) begin
    logic [AW-1:0] eff;
    eff = mem_addr & ~alias_mask;
    if (mem_we) mem[eff] <= mem_wdata;
    if (mem_re)
      mem_rdata <= ((mem[eff] | stuck_or) & stuck_and)
                   ^ ((int'(eff) == bad_addr) ? bad_xor : '0);
    if (cnt_clr) begin
      n_wr <= 0; n_rd <= 0;
    end else begin
      if (mem_we) n_wr <= n_wr + 1;
      if (mem_re) n_rd <= n_rd + 1;
    end
    if (mem_we && mem_re) n_ovl <= n_ovl + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_writes(input logic m);
    int n = D * (m ? 3 : 4);
    for (int b = 16; b < D; b = b * 2) n += b;
    return n;
  endfunction

  function automatic int exp_reads(input logic m);
    int n = D * (m ? 2 : 3);
    for (int b = 16; b < D; b = b * 2) n += D - b;
    return n;
  endfunction

  task automatic clear_faults();
    stuck_or = '0; stuck_and = '1; alias_mask = '0; bad_addr = -1; bad_xor = '0;
  endtask

  // start a run; optionally pulse start again at edge count poke
  task automatic run_test(input logic m, input int poke, output int cyc);
    @(negedge clk);
    cnt_clr = 1'b1; mode = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0; cnt_clr = 1'b0;
    cyc = 0;
    while (!done && cyc < 4000) begin
      @(posedge clk); #1;
      cyc++;
      if (cyc == poke) begin start = 1'b1; mode = ~m; end
      else start = 1'b0;
    end
    start = 1'b0;
    if (!done) begin
      failures++;
      $display("FAIL run timeout actual=%0d expected=done", cyc);
    end
  endtask

  task automatic t_reset();
    chk("R1 busy after reset", busy, 0);
    chk("R1 done after reset", done, 0);
    chk("R1 pass after reset", pass, 0);
    chk("R1 fail after reset", fail, 0);
    chk("R1 strobes after reset", {mem_we, mem_re}, 0);
  endtask

  task automatic t_clean_solid();
    int cyc;
    clear_faults();
    run_test(1'b0, -1, cyc);
    chk("R8 solid run length", cyc, (AW + 3) * D + 3);
    chk("R8 pass with done", pass, 1);
    chk("R6 no fail", fail, 0);
    chk("R2 write count", n_wr, exp_writes(1'b0));
    chk("R4 read count", n_rd, exp_reads(1'b0));
    @(posedge clk); #1;
    chk("R8 done one cycle", done, 0);
    chk("R8 pass held", pass, 1);
    chk("R8 busy low", busy, 0);
  endtask

  task automatic t_clean_check();
    int cyc;
    clear_faults();
    run_test(1'b1, -1, cyc);
    chk("R3 check run length", cyc, (AW + 1) * D + 3);
    chk("R3 pass", pass, 1);
    chk("R3 write count", n_wr, exp_writes(1'b1));
    chk("R3 read count", n_rd, exp_reads(1'b1));
  endtask

  task automatic t_stuck_bit();
    int cyc;
    clear_faults();
    stuck_or = 16'h0008;
    run_test(1'b0, -1, cyc);
    chk("R6 stuck fail", fail, 1);
    chk("R6 stuck pass low", pass, 0);
    chk("R6 stuck addr", err_addr, 0);
    chk("R6 stuck exp", err_exp, 16'h0000);
    chk("R6 stuck obs", err_obs, 16'h0008);
    chk("R6 stuck phase", err_phase, 1);
    chk("R7 early stop", cyc < (AW + 3) * D + 3, 1);
  endtask

  task automatic t_check_fault();
    int cyc;
    clear_faults();
    stuck_and = 16'hFFFE;
    run_test(1'b1, -1, cyc);
    chk("R6 check-mode addr", err_addr, 0);
    chk("R6 check-mode exp", err_exp, 16'h5555);
    chk("R6 check-mode obs", err_obs, 16'h5554);
    chk("R6 check-mode phase", err_phase, 2);
  endtask

  task automatic t_bad_cell();
    int cyc;
    clear_faults();
    bad_addr = 37; bad_xor = 16'h0200;
    run_test(1'b0, -1, cyc);
    chk("R7 bad cell fail", fail, 1);
    chk("R7 bad cell addr", err_addr, 37);
    chk("R7 bad cell obs", err_obs, 16'h0200);
    chk("R7 bad cell phase", err_phase, 1);
    chk("R7 bad cell busy", busy, 0);
  endtask

  task automatic t_alias(input int bitno, input int exp_addr);
    int cyc;
    clear_faults();
    alias_mask = AW'(1 << bitno);
    run_test(1'b0, -1, cyc);
    chk("R5 alias fail", fail, 1);
    chk("R5 alias addr", err_addr, exp_addr);
    chk("R5 alias exp", err_exp, 16'h0000);
    chk("R5 alias obs", err_obs, 16'hFFFF);
    chk("R5 alias phase", err_phase, 3);
    chk("R5 alias pass low", pass, 0);
  endtask

  task automatic t_start_ignored();
    int cyc;
    clear_faults();
    run_test(1'b0, 100, cyc);
    chk("R9 length unchanged", cyc, (AW + 3) * D + 3);
    chk("R9 pass", pass, 1);
    chk("R9 mode kept", n_rd, exp_reads(1'b0));
  endtask

  task automatic t_mid_reset();
    @(negedge clk);
    mode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (50) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_clean_solid();
    t_clean_check();
    t_stuck_bit();
    t_clean_solid();   // R1: status of the failed run is cleared by start
    t_check_fault();
    t_bad_cell();
    t_alias(4, 16);
    t_alias(5, 32);
    t_start_ignored();
    t_mid_reset();
    t_clean_check();
    chk("R10 strobes never overlap", n_ovl, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule